// File: doc/BRIEF.md
# Ethernet MAC Control Register with Statistics Counter Bank

This block holds the 32-bit control word of an Ethernet MAC and a small bank of statistics counters that the word governs. Software writes the word over a simple register bus. Write-one command bits ask for a pause frame, either with zero quanta or with the programmed quantum. The request is latched and released as a one-cycle strobe on the first cycle the transmitter reports idle. Persistent bits drive half-duplex back-pressure, gate the management clock and data-enable lines coming from an external shift engine, and unlock the counters for direct writes.

The counters count per-counter event strobes and saturate at all-ones. Two test commands act on every counter at once: one clears them and one adds one to them. A 16-bit pause quantum register sits beside the control word. Reads are combinational from the addressed register.

Address map, in bytes: control word at 0x00, pause quantum at 0x04, counter i at 0x10 + 4*i.

Top module: `mac_ctrl_regbank`

## Requirements
- R1: After reset the control word, the pause quantum and every counter read 0, and pause_req, back_pressure, mdc_out and mdio_oe_out are low.
- R2: Control word reads return 0 in bits 31:13, 10:9, 6:5 and 3:0. Command bits 12, 11, 6 and 5 never read back as 1. Bits 8, 7 and 4 read back the last value written to them.
- R3: Writing 1 to bit 12 latches a zero-quantum pause request. The request is held while tx_idle is low. It appears as a single-cycle pause_req with pause_quanta = 0 one cycle after the first clock edge at which tx_idle is high.
- R4: Writing 1 to bit 11 latches a pause request that is issued the same way as in R3, with pause_quanta equal to the pause quantum register. That register is 16 bits wide at 0x04, and its upper read bits are 0.
- R5: When both pause requests are pending, the zero-quantum request is issued first and the other request on the next idle cycle.
- R6: back_pressure is high exactly when control bit 8 is 1 and half_duplex is 1.
- R7: When control bit 4 is 0, mdc_out and mdio_oe_out are 0. When it is 1, they follow mdc_in and mdio_oe_in.
- R8: Each counter adds one for each cycle in which its cnt_evt bit is high, and it stays at all-ones instead of wrapping.
- R9: Writing 1 to bit 6 adds one to every counter. A counter whose event strobe is high in the same cycle gains two, still saturating.
- R10: Writing 1 to bit 5 zeroes every counter. The clear wins over a same-cycle increment command and over same-cycle events.
- R11: While bit 7 is 1, a bus write to a counter address loads that counter. While bit 7 is 0, such a write leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cnt_evt | input | 4 | Per-counter event strobes |
| tx_idle | input | 1 | Transmitter idle flag |
| half_duplex | input | 1 | MAC operating in half duplex |
| mdc_in | input | 1 | Management clock from the shift engine |
| mdio_oe_in | input | 1 | Management data enable from the shift engine |
| pause_req | output | 1 | One-cycle pause frame request |
| pause_quanta | output | 16 | Quantum that goes with pause_req |
| back_pressure | output | 1 | Force collisions on received frames |
| mdc_out | output | 1 | Gated management clock |
| mdio_oe_out | output | 1 | Gated management data output enable |

## Verification
The clear and the increment commands can fall in the same cycle in two ways: both bits set in one control write, or a control write landing in a cycle where event strobes are also high. The bench provokes both cases. It sets bits 6 and 5 together, and it holds every event strobe high across a clear write, and it judges the result by reading each counter back as 0. The two pause requests can also collide when a single write sets bits 12 and 11. The bench checks that the zero-quanta strobe comes out first and the programmed quantum comes out on the following idle cycle.

// File: rtl/mac_ctrl_pkg.sv
package mac_ctrl_pkg;
  localparam int BIT_ZQ   = 12;
  localparam int BIT_PQ   = 11;
  localparam int BIT_BP   = 8;
  localparam int BIT_WE   = 7;
  localparam int BIT_INC  = 6;
  localparam int BIT_CLR  = 5;
  localparam int BIT_MGMT = 4;

  localparam logic [7:0] ADDR_CTRL     = 8'h00;
  localparam logic [7:0] ADDR_QUANT    = 8'h04;
  localparam logic [7:0] ADDR_CNT_BASE = 8'h10;

  // Assemble the readable view of the control word; all other bits are zero.
  function automatic logic [31:0] ctrl_view(logic bp, logic we, logic mgmt);
    logic [31:0] v;
    v = '0;
    v[BIT_BP]   = bp;
    v[BIT_WE]   = we;
    v[BIT_MGMT] = mgmt;
    return v;
  endfunction
endpackage

// File: rtl/mac_ctrl_cmd.sv
module mac_ctrl_cmd
  import mac_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  output logic        bp_bit,
  output logic        we_bit,
  output logic        mgmt_bit,
  output logic        zq_pulse,
  output logic        pq_pulse,
  output logic        inc_pulse,
  output logic        clr_pulse,
  output logic [31:0] ctrl_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_bit   <= 1'b0;
      we_bit   <= 1'b0;
      mgmt_bit <= 1'b0;
    end else if (wr_ctrl) begin
      bp_bit   <= wdata[BIT_BP];
      we_bit   <= wdata[BIT_WE];
      mgmt_bit <= wdata[BIT_MGMT];
    end
  end

  assign zq_pulse  = wr_ctrl & wdata[BIT_ZQ];
  assign pq_pulse  = wr_ctrl & wdata[BIT_PQ];
  assign inc_pulse = wr_ctrl & wdata[BIT_INC];
  assign clr_pulse = wr_ctrl & wdata[BIT_CLR];
  assign ctrl_rd   = ctrl_view(bp_bit, we_bit, mgmt_bit);
endmodule

// File: rtl/mac_ctrl_pause.sv
module mac_ctrl_pause #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_zero,
  input  logic          set_quant,
  input  logic          tx_idle,
  input  logic [QW-1:0] quantum,
  output logic          pend_zero,
  output logic          pend_quant,
  output logic          pause_req,
  output logic [QW-1:0] pause_quanta
);
  logic serve_zero, serve_quant;

  assign serve_zero  = tx_idle & pend_zero;
  assign serve_quant = tx_idle & ~pend_zero & pend_quant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_zero    <= 1'b0;
      pend_quant   <= 1'b0;
      pause_req    <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pend_zero  <= (pend_zero & ~serve_zero) | set_zero;
      pend_quant <= (pend_quant & ~serve_quant) | set_quant;
      pause_req  <= serve_zero | serve_quant;
      if (serve_zero)       pause_quanta <= '0;
      else if (serve_quant) pause_quanta <= quantum;
    end
  end
endmodule

// File: rtl/mac_ctrl_stats.sv
module mac_ctrl_stats #(
  parameter int N_CNT = 4,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   inc,
  input  logic                   wr_allow,
  input  logic [N_CNT-1:0]       wr_sel,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic [N_CNT-1:0]       evt,
  output logic [N_CNT*CNT_W-1:0] cnt_flat
);
  // Saturating add of 0..2 to a counter value.
  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v, logic [1:0] amt);
    logic [CNT_W:0] s;
    s = {1'b0, v} + {{(CNT_W-1){1'b0}}, amt};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                     q <= '0;
      else if (clr)                   q <= '0;
      else if (wr_allow && wr_sel[g]) q <= wr_data;
      else if (inc || evt[g])         q <= bump(q, {1'b0, inc} + {1'b0, evt[g]});
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = q;
  end
endmodule

// File: rtl/mac_ctrl_regbank.sv
module mac_ctrl_regbank
  import mac_ctrl_pkg::*;
#(
  parameter int N_CNT = 4,
  parameter int CNT_W = 16,
  parameter int QW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_CNT-1:0]  cnt_evt,
  input  logic              tx_idle,
  input  logic              half_duplex,
  input  logic              mdc_in,
  input  logic              mdio_oe_in,
  output logic              pause_req,
  output logic [QW-1:0]     pause_quanta,
  output logic              back_pressure,
  output logic              mdc_out,
  output logic              mdio_oe_out
);
  logic                   bp_bit, we_bit, mgmt_en;
  logic                   zq_pulse, pq_pulse, inc_pulse, clr_pulse;
  logic [31:0]            ctrl_rd;
  logic [QW-1:0]          quant_q;
  logic                   pend_zero, pend_quant;
  logic [N_CNT-1:0]       cnt_wr_sel;
  logic                   cnt_load;
  logic [N_CNT*CNT_W-1:0] cnt_flat;

  mac_ctrl_cmd u_cmd (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(bus_wr && bus_addr == ADDR_CTRL), .wdata(bus_wdata),
    .bp_bit(bp_bit), .we_bit(we_bit), .mgmt_bit(mgmt_en),
    .zq_pulse(zq_pulse), .pq_pulse(pq_pulse),
    .inc_pulse(inc_pulse), .clr_pulse(clr_pulse), .ctrl_rd(ctrl_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                              quant_q <= '0;
    else if (bus_wr && bus_addr == ADDR_QUANT) quant_q <= bus_wdata[QW-1:0];
  end

  mac_ctrl_pause #(.QW(QW)) u_pause (
    .clk(clk), .rst_n(rst_n), .set_zero(zq_pulse), .set_quant(pq_pulse),
    .tx_idle(tx_idle), .quantum(quant_q),
    .pend_zero(pend_zero), .pend_quant(pend_quant),
    .pause_req(pause_req), .pause_quanta(pause_quanta)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_sel
    assign cnt_wr_sel[i] = bus_wr && (bus_addr == ADDR_CNT_BASE + 8'(4 * i));
  end
  assign cnt_load = we_bit && (|cnt_wr_sel);

  mac_ctrl_stats #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .inc(inc_pulse),
    .wr_allow(we_bit), .wr_sel(cnt_wr_sel), .wr_data(bus_wdata[CNT_W-1:0]),
    .evt(cnt_evt), .cnt_flat(cnt_flat)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CTRL)       bus_rdata = ctrl_rd;
    else if (bus_addr == ADDR_QUANT) bus_rdata = 32'(quant_q);
    for (int i = 0; i < N_CNT; i++)
      if (bus_addr == ADDR_CNT_BASE + 8'(4 * i))
        bus_rdata = 32'(cnt_flat[i*CNT_W +: CNT_W]);
  end

  assign back_pressure = bp_bit & half_duplex;
  assign mdc_out       = mgmt_en & mdc_in;
  assign mdio_oe_out   = mgmt_en & mdio_oe_in;
endmodule

// File: rtl/mac_ctrl_regbank_chk.sv
module mac_ctrl_regbank_chk #(
  parameter int N_CNT = 4,
  parameter int CNT_W = 16,
  parameter int QW    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [7:0]             bus_addr,
  input logic [31:0]            bus_rdata,
  input logic                   tx_idle,
  input logic                   half_duplex,
  input logic                   back_pressure,
  input logic                   mgmt_en,
  input logic                   mdc_out,
  input logic                   mdio_oe_out,
  input logic                   pause_req,
  input logic [QW-1:0]          pause_quanta,
  input logic                   pend_zero,
  input logic                   clr_pulse,
  input logic                   cnt_load,
  input logic [N_CNT*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h00) |-> (bus_rdata[31:9] == '0 && bus_rdata[6:5] == '0 && bus_rdata[3:0] == '0));
  // R3
  pause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> $past(tx_idle));
  // R5
  zero_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && $past(pend_zero)) |-> (pause_quanta == '0));
  // R6
  bp_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_duplex |-> !back_pressure);
  // R7
  mgmt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_en |-> (!mdc_out && !mdio_oe_out));
  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cnt_flat == '0));
  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_flat[CNT_W-1:0]) == CMAX && !$past(clr_pulse) && !$past(cnt_load))
      |-> (cnt_flat[CNT_W-1:0] == CMAX));
endmodule

bind mac_ctrl_regbank mac_ctrl_regbank_chk #(.N_CNT(N_CNT), .CNT_W(CNT_W), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .tx_idle(tx_idle), .half_duplex(half_duplex), .back_pressure(back_pressure),
  .mgmt_en(mgmt_en), .mdc_out(mdc_out), .mdio_oe_out(mdio_oe_out),
  .pause_req(pause_req), .pause_quanta(pause_quanta), .pend_zero(pend_zero),
  .clr_pulse(clr_pulse), .cnt_load(cnt_load), .cnt_flat(cnt_flat)
);

// File: tb/mac_ctrl_regbank_tb.sv
`timescale 1ns/1ps
module mac_ctrl_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cnt_evt = '0;
  logic        tx_idle = 1'b0, half_duplex = 1'b0, mdc_in = 1'b0, mdio_oe_in = 1'b0;
  logic        pause_req, back_pressure, mdc_out, mdio_oe_out;
  logic [15:0] pause_quanta;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  mac_ctrl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_evt(cnt_evt),
    .tx_idle(tx_idle), .half_duplex(half_duplex), .mdc_in(mdc_in),
    .mdio_oe_in(mdio_oe_in), .pause_req(pause_req), .pause_quanta(pause_quanta),
    .back_pressure(back_pressure), .mdc_out(mdc_out), .mdio_oe_out(mdio_oe_out)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0,        8'd1},  // R1 control word
    '{1'b1, 8'h04, 32'h0,        8'd1},  // R1 quantum
    '{1'b1, 8'h10, 32'h0,        8'd1},  // R1 counter 0
    '{1'b0, 8'h00, 32'hFFFFE7FF, 8'd2},  // R2 all bits but pause commands
    '{1'b1, 8'h00, 32'h00000190, 8'd2},  // R2 only 8,7,4 read back
    '{1'b1, 8'h10, 32'h0,        8'd10}, // R10 clear beat increment
    '{1'b1, 8'h1C, 32'h0,        8'd10}, // R10 counter 3
    '{1'b0, 8'h04, 32'hABCD1234, 8'd4},  // R4 quantum write
    '{1'b1, 8'h04, 32'h00001234, 8'd4},  // R4 16 bits kept
    '{1'b0, 8'h14, 32'h000000FE, 8'd11}, // R11 load while enabled
    '{1'b1, 8'h14, 32'h000000FE, 8'd11}, // R11
    '{1'b0, 8'h00, 32'h00000040, 8'd9},  // R9 increment all, bit7 off
    '{1'b1, 8'h00, 32'h0,        8'd2},  // R2 command bit reads 0
    '{1'b1, 8'h14, 32'h000000FF, 8'd9},  // R9
    '{1'b1, 8'h10, 32'h00000001, 8'd9},  // R9
    '{1'b0, 8'h18, 32'h00000055, 8'd11}, // R11 write while locked
    '{1'b1, 8'h18, 32'h00000001, 8'd11}, // R11 unchanged
    '{1'b0, 8'h00, 32'h00000020, 8'd10}, // R10 clear
    '{1'b1, 8'h14, 32'h0,        8'd10}  // R10
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_evt(logic [3:0] m);
    @(negedge clk); cnt_evt = m;
    @(negedge clk); cnt_evt = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 outputs after reset
    check("R1", {28'b0, pause_req, back_pressure, mdc_out, mdio_oe_out}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rd_chk($sformatf("R%0d", VEC[i].req), VEC[i].addr, VEC[i].data);
      else           wr(VEC[i].addr, VEC[i].data);
    end

    // R8 saturation
    wr(8'h00, 32'h80);
    wr(8'h10, 32'hFFFE);
    wr(8'h00, 32'h0);
    pulse_evt(4'h1);
    pulse_evt(4'h1);
    rd_chk("R8", 8'h10, 32'hFFFF);
    // R8 plain counting
    wr(8'h00, 32'h20);
    pulse_evt(4'h4); pulse_evt(4'h4); pulse_evt(4'h4);
    rd_chk("R8", 8'h18, 32'h3);
    // R9 increment with same-cycle event, saturating near top
    wr(8'h00, 32'h80);
    wr(8'h1C, 32'hFFFE);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h40; cnt_evt = 4'h8;
    @(negedge clk);
    bus_wr = 1'b0; cnt_evt = '0;
    rd_chk("R9", 8'h1C, 32'hFFFF);
    rd_chk("R9", 8'h14, 32'h1);
    // R9 increment plus event without saturation
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h40; cnt_evt = 4'h2;
    @(negedge clk);
    bus_wr = 1'b0; cnt_evt = '0;
    rd_chk("R9", 8'h14, 32'h3);
    // R10 clear with increment and all events in the same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h60; cnt_evt = 4'hF;
    @(negedge clk);
    bus_wr = 1'b0; cnt_evt = '0;
    for (int i = 0; i < 4; i++) rd_chk("R10", 8'h10 + 8'(4 * i), 32'h0);

    // R3 zero-quantum request held until idle
    tx_idle = 1'b0;
    wr(8'h00, 32'h1000);
    for (int i = 0; i < 3; i++) begin
      check("R3", {31'b0, pause_req}, 32'h0);
      @(negedge clk);
    end
    tx_idle = 1'b1;
    @(negedge clk);
    check("R3", {31'b0, pause_req}, 32'h1);
    check("R3", {16'b0, pause_quanta}, 32'h0);
    @(negedge clk);
    check("R3", {31'b0, pause_req}, 32'h0);
    // R4 and R5 both requests at once
    tx_idle = 1'b0;
    wr(8'h00, 32'h1800);
    tx_idle = 1'b1;
    @(negedge clk);
    check("R5", {15'b0, pause_req, pause_quanta}, 32'h10000);
    @(negedge clk);
    check("R4", {15'b0, pause_req, pause_quanta}, 32'h11234);
    @(negedge clk);
    check("R5", {31'b0, pause_req}, 32'h0);
    tx_idle = 1'b0;

    // R6 back-pressure
    wr(8'h00, 32'h100);
    half_duplex = 1'b0; #1;
    check("R6", {31'b0, back_pressure}, 32'h0);
    half_duplex = 1'b1; #1;
    check("R6", {31'b0, back_pressure}, 32'h1);
    wr(8'h00, 32'h0); #1;
    check("R6", {31'b0, back_pressure}, 32'h0);

    // R7 management gating
    mdc_in = 1'b1; mdio_oe_in = 1'b1; #1;
    check("R7", {30'b0, mdc_out, mdio_oe_out}, 32'h0);
    wr(8'h00, 32'h10); #1;
    check("R7", {30'b0, mdc_out, mdio_oe_out}, 32'h3);
    mdc_in = 1'b0; #1;
    check("R7", {30'b0, mdc_out, mdio_oe_out}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule